// File: doc/BRIEF.md
# Request List and Fill Engine

This block sits between client logic and an external memory controller. A client places a list of two-word entries in a small local list memory, then starts the engine with the list's base index and its own client number. The engine walks the list one entry at a time and turns each entry into one or more commands for the memory controller. It waits for the controller to accept each command before it fetches the next entry.

Entries can read a burst into the client's staging buffer or write a burst out of it, which makes a copy between two external addresses a read entry followed by a write entry. Other entries store a byte, 16-bit or 32-bit fill pattern for the owning client and switch fill mode on or off. While fill mode is on, a write entry does not take data from the staging buffer. It repeats the stored pattern over the whole requested count. A fill may be very large, so the engine cuts it into controller bursts no longer than a configured maximum. The list ends at an all-zero request word. The engine then pulses `done` and clears that client's fill mode.

Top module: `rlf_engine`

## Requirements
- R1: While `busy` is low, a cycle with `start_valid` high latches `start_client` and `start_base`, and `busy` is high from the next cycle. A `start_valid` seen while `busy` is high is ignored and does not cause a second `done`.
- R2: Entry k of a list occupies list words base+2k (request) and base+2k+1 (data), and the index wraps at the memory depth. In the request word, bits [31:28] hold the operation: 1 read, 2 write, 3 set fill pattern, 4 fill mode. Bits [23:0] hold the external address. A non-zero request word with any other operation code issues no command.
- R3: An all-zero request word ends the list. `done` is then high for exactly one cycle, `busy` falls in that same cycle, and this happens only after every command of the list has been acknowledged. No command follows it.
- R4: A set-fill entry takes the element size from request bits [1:0] (0 byte, 1 16-bit, 2 or 3 32-bit) and the pattern from the low bits of the data word. It turns fill mode on for the owning client. A fill command presents the pattern replicated across all 32 bits of `mc_pattern`.
- R5: A write entry in fill mode covers count << size bytes, with the count taken from data word bits [LEN_W-1:0]. It is issued as bursts with `mc_fill` high and `mc_write` high. Every burst has length MAX_BURST bytes except the last, which holds the remainder. Burst addresses are consecutive modulo 2^ADDR_W. A count of zero issues nothing.
- R6: Fill mode persists across write entries until a fill-mode entry with request bit 0 clear turns it off, or until the list ends. A fill-mode entry with bit 0 set turns it back on with the client's stored pattern and size. The pattern and size of each client are independent of the other clients and survive the end of a list.
- R7: A read entry issues one command with `mc_write` low. A write entry outside fill mode issues one command with `mc_write` high and `mc_fill` low, so its data comes from the client's staging buffer. In both cases the length is the data word and `mc_client` is the owning client.
- R8: While `mc_valid` is high and `mc_ack` is low, every command output stays unchanged.
- R9: After reset, `busy`, `done` and `mc_valid` are low and fill mode is off for every client.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start a list walk |
| start_client | input | CLI_W | Client that owns the list |
| start_base | input | IDX_W | List memory index of the first entry |
| lw_en | input | 1 | List memory write enable |
| lw_addr | input | IDX_W | List memory write index |
| lw_data | input | 32 | List memory write word |
| mc_ack | input | 1 | Controller accepts the current command |
| busy | output | 1 | A list is being walked |
| done | output | 1 | One-cycle pulse at list end |
| mc_valid | output | 1 | Command present |
| mc_write | output | 1 | 1 write, 0 read |
| mc_fill | output | 1 | Write data is the fill pattern, not the staging buffer |
| mc_pattern | output | 32 | Replicated fill pattern |
| mc_addr | output | ADDR_W | External start address of the command |
| mc_len | output | LEN_W | Command length in bytes |
| mc_client | output | CLI_W | Client whose staging buffer is used |

## Verification
A wrong fill-state bit shows at the ports as early as the next write entry of that client. The write appears as a staging-buffer write where a pattern fill was expected, or the other way round. A stale pattern shows up on `mc_pattern` of the first burst. A wrong remaining-byte count or burst address appears on the second burst of a long fill, or as an extra or missing burst before `done`. A wrong list pointer appears in the first command after the bad entry, or as a missing or early `done`.

// File: rtl/rlf_pkg.sv
package rlf_pkg;

  typedef enum logic [3:0] {
    OP_READ    = 4'd1,
    OP_WRITE   = 4'd2,
    OP_SETFILL = 4'd3,
    OP_MODE    = 4'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_REQ,
    S_FETCH_DAT,
    S_DECODE,
    S_ISSUE
  } state_e;

  // spread an element pattern over a 32-bit word
  function automatic logic [31:0] spread(input logic [1:0] sz, input logic [31:0] p);
    case (sz)
      2'd0:    return {4{p[7:0]}};
      2'd1:    return {2{p[15:0]}};
      default: return p;
    endcase
  endfunction

endpackage

// File: rtl/rlf_list_mem.sv
module rlf_list_mem #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [31:0]      rdata
);

  logic [31:0] mem [DEPTH];

  // one write port, one registered read port: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rlf_fill_ctx.sv
module rlf_fill_ctx #(
  parameter int N_CLIENTS = 4,
  parameter int CLI_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [CLI_W-1:0] set_client,
  input  logic [1:0]       set_size,
  input  logic [31:0]      set_pat,
  input  logic             mode_en,
  input  logic [CLI_W-1:0] mode_client,
  input  logic             mode_val,
  input  logic [CLI_W-1:0] rd_client,
  output logic             rd_mode,
  output logic [1:0]       rd_size,
  output logic [31:0]      rd_pat
);
  import rlf_pkg::*;

  logic        mode_q [N_CLIENTS];
  logic [1:0]  size_q [N_CLIENTS];
  logic [31:0] pat_q  [N_CLIENTS];

  for (genvar c = 0; c < N_CLIENTS; c++) begin : g_cli
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[c] <= 1'b0;
        size_q[c] <= 2'd2;
        pat_q[c]  <= '0;
      end else if (set_en && set_client == CLI_W'(c)) begin
        mode_q[c] <= 1'b1;
        size_q[c] <= set_size;
        pat_q[c]  <= spread(set_size, set_pat);
      end else if (mode_en && mode_client == CLI_W'(c)) begin
        mode_q[c] <= mode_val;
      end
    end

    // R6: a mode-off request for this client leaves fill mode off
    p_mode_off_r6: assert property (@(posedge clk) disable iff (rst)
      (mode_en && !mode_val && !set_en && mode_client == CLI_W'(c)) |=> !mode_q[c]);
  end

  assign rd_mode = mode_q[rd_client];
  assign rd_size = size_q[rd_client];
  assign rd_pat  = pat_q[rd_client];

endmodule

// File: rtl/rlf_engine.sv
module rlf_engine #(
  parameter int N_CLIENTS  = 4,
  parameter int LIST_DEPTH = 64,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 24,
  parameter int MAX_BURST  = 16,
  localparam int CLI_W     = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1,
  localparam int IDX_W     = $clog2(LIST_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic [CLI_W-1:0]  start_client,
  input  logic [IDX_W-1:0]  start_base,
  input  logic              lw_en,
  input  logic [IDX_W-1:0]  lw_addr,
  input  logic [31:0]       lw_data,
  input  logic              mc_ack,
  output logic              busy,
  output logic              done,
  output logic              mc_valid,
  output logic              mc_write,
  output logic              mc_fill,
  output logic [31:0]       mc_pattern,
  output logic [ADDR_W-1:0] mc_addr,
  output logic [LEN_W-1:0]  mc_len,
  output logic [CLI_W-1:0]  mc_client
);
  import rlf_pkg::*;

  localparam int REM_W = LEN_W + 3;

  state_e            st;
  logic [IDX_W-1:0]  ptr;
  logic [CLI_W-1:0]  cli;
  logic [31:0]       req_q;
  logic [31:0]       rdata;
  logic [IDX_W-1:0]  raddr;
  logic [REM_W-1:0]  rem;
  logic [REM_W-1:0]  rem_after;
  logic [REM_W-1:0]  fill_total;
  op_e               op;
  logic              is_end;
  logic              dec;
  logic              fc_mode;
  logic [1:0]        fc_size;
  logic [31:0]       fc_pat;
  logic [1:0]        set_size;

  function automatic logic [LEN_W-1:0] cap(input logic [REM_W-1:0] x);
    return (x > REM_W'(MAX_BURST)) ? LEN_W'(MAX_BURST) : LEN_W'(x);
  endfunction

  assign op         = op_e'(req_q[31:28]);
  assign is_end     = (req_q == '0);
  assign dec        = (st == S_DECODE);
  assign raddr      = (st == S_FETCH_DAT) ? ptr + IDX_W'(1) : ptr;
  assign set_size   = (req_q[1:0] == 2'd3) ? 2'd2 : req_q[1:0];
  assign fill_total = REM_W'(rdata[LEN_W-1:0]) << fc_size;
  assign rem_after  = rem - REM_W'(mc_len);
  assign mc_client  = cli;

  rlf_list_mem #(.DEPTH(LIST_DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk   (clk),
    .we    (lw_en),
    .waddr (lw_addr),
    .wdata (lw_data),
    .raddr (raddr),
    .rdata (rdata)
  );

  rlf_fill_ctx #(.N_CLIENTS(N_CLIENTS), .CLI_W(CLI_W)) u_fill (
    .clk         (clk),
    .rst         (rst),
    .set_en      (dec && !is_end && op == OP_SETFILL),
    .set_client  (cli),
    .set_size    (set_size),
    .set_pat     (rdata),
    .mode_en     (dec && (is_end || op == OP_MODE)),
    .mode_client (cli),
    .mode_val    (!is_end && req_q[0]),
    .rd_client   (cli),
    .rd_mode     (fc_mode),
    .rd_size     (fc_size),
    .rd_pat      (fc_pat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ptr        <= '0;
      cli        <= '0;
      req_q      <= '0;
      rem        <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      mc_valid   <= 1'b0;
      mc_write   <= 1'b0;
      mc_fill    <= 1'b0;
      mc_pattern <= '0;
      mc_addr    <= '0;
      mc_len     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start_valid) begin
          ptr  <= start_base;
          cli  <= start_client;
          busy <= 1'b1;
          st   <= S_FETCH_REQ;
        end
        S_FETCH_REQ: st <= S_FETCH_DAT;
        S_FETCH_DAT: begin
          req_q <= rdata;
          st    <= S_DECODE;
        end
        S_DECODE: begin
          // default: step to the next entry
          ptr <= ptr + IDX_W'(2);
          st  <= S_FETCH_REQ;
          mc_addr <= req_q[ADDR_W-1:0];
          if (is_end) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else if (op == OP_READ || (op == OP_WRITE && !fc_mode)) begin
            mc_valid <= 1'b1;
            mc_write <= (op == OP_WRITE);
            mc_fill  <= 1'b0;
            mc_len   <= rdata[LEN_W-1:0];
            ptr      <= ptr;
            st       <= S_ISSUE;
          end else if (op == OP_WRITE && fill_total != '0) begin
            mc_valid   <= 1'b1;
            mc_write   <= 1'b1;
            mc_fill    <= 1'b1;
            mc_pattern <= fc_pat;
            mc_len     <= cap(fill_total);
            rem        <= fill_total;
            ptr        <= ptr;
            st         <= S_ISSUE;
          end
        end
        S_ISSUE: if (mc_ack) begin
          if (mc_fill && rem_after != '0) begin
            rem     <= rem_after;
            mc_addr <= mc_addr + ADDR_W'(mc_len);
            mc_len  <= cap(rem_after);
          end else begin
            mc_valid <= 1'b0;
            ptr      <= ptr + IDX_W'(2);
            st       <= S_FETCH_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: a pending command is held until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mc_valid && !mc_ack) |=> (mc_valid && $stable(mc_addr) && $stable(mc_len)
                               && $stable(mc_write) && $stable(mc_fill) && $stable(mc_pattern)));

  // R5: fill bursts are never empty and never exceed the cap
  p_burst_cap_r5: assert property (@(posedge clk) disable iff (rst)
    (mc_valid && mc_fill) |-> (mc_len != '0 && mc_len <= LEN_W'(MAX_BURST)));

  // R3: the end pulse comes with the engine idle and no command open
  p_done_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mc_valid));

  // R1: commands only while a list is being walked
  p_valid_busy_r1: assert property (@(posedge clk) disable iff (rst)
    mc_valid |-> busy);

  // R1: an idle start raises busy on the next cycle
  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_valid) |=> busy);

endmodule

// File: tb/tb_rlf_engine.sv
module tb_rlf_engine;

  localparam int NC = 4;
  localparam int DEPTH = 64;
  localparam int AW = 24;
  localparam int LW = 24;
  localparam int MB = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_valid = 1'b0;
  logic [1:0]    start_client = '0;
  logic [5:0]    start_base = '0;
  logic          lw_en = 1'b0;
  logic [5:0]    lw_addr = '0;
  logic [31:0]   lw_data = '0;
  logic          mc_ack = 1'b0;
  logic          busy, done, mc_valid, mc_write, mc_fill;
  logic [31:0]   mc_pattern;
  logic [AW-1:0] mc_addr;
  logic [LW-1:0] mc_len;
  logic [1:0]    mc_client;

  rlf_engine #(.N_CLIENTS(NC), .LIST_DEPTH(DEPTH), .ADDR_W(AW), .LEN_W(LW), .MAX_BURST(MB)) dut (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_client(start_client),
    .start_base(start_base), .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data),
    .mc_ack(mc_ack), .busy(busy), .done(done), .mc_valid(mc_valid), .mc_write(mc_write),
    .mc_fill(mc_fill), .mc_pattern(mc_pattern), .mc_addr(mc_addr), .mc_len(mc_len),
    .mc_client(mc_client)
  );

  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int done_cnt = 0;
  int ack_delay = 0;
  int wcnt = 0;
  bit finished = 0;

  // command log and expectation
  int          n_log = 0;
  bit          lg_w [256];
  bit          lg_f [256];
  logic [23:0] lg_a [256];
  int          lg_l [256];
  int          lg_c [256];
  logic [31:0] lg_p [256];
  int          n_exp = 0;
  bit          ex_w [256];
  bit          ex_f [256];
  logic [23:0] ex_a [256];
  int          ex_l [256];
  int          ex_c [256];
  logic [31:0] ex_p [256];

  logic [31:0] lastpat [NC];
  int          lastsz  [NC];

  always @(posedge clk) cycles++;

  // controller model and monitor, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      mc_ack = 1'b0;
      wcnt = 0;
    end else begin
      if (done) done_cnt++;
      if (mc_ack) mc_ack = 1'b0;
      else if (mc_valid) begin
        if (wcnt >= ack_delay) begin
          if (n_log < 256) begin
            lg_w[n_log] = mc_write; lg_f[n_log] = mc_fill; lg_a[n_log] = mc_addr;
            lg_l[n_log] = int'(mc_len); lg_c[n_log] = int'(mc_client); lg_p[n_log] = mc_pattern;
          end
          n_log++;
          mc_ack = 1'b1;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] spread(input int sz, input logic [31:0] p);
    if (sz == 0) return {4{p[7:0]}};
    if (sz == 1) return {2{p[15:0]}};
    return p;
  endfunction

  function automatic logic [31:0] mkreq(input int op, input logic [23:0] low);
    return {4'(op), 4'h0, low};
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    lw_en = 1'b1; lw_addr = 6'(idx); lw_data = d;
    @(negedge clk);
    lw_en = 1'b0;
  endtask

  task automatic add_exp(input bit w, input bit f, input logic [23:0] a, input int l,
                         input int c, input logic [31:0] p);
    ex_w[n_exp] = w; ex_f[n_exp] = f; ex_a[n_exp] = a; ex_l[n_exp] = l;
    ex_c[n_exp] = c; ex_p[n_exp] = p;
    n_exp++;
  endtask

  task automatic exp_fill(input int c, input logic [23:0] a, input int bytes, input logic [31:0] p);
    int left;
    logic [23:0] ad;
    left = bytes;
    ad = a;
    while (left > 0) begin
      int l;
      l = (left > MB) ? MB : left;
      add_exp(1'b1, 1'b1, ad, l, c, p);
      ad = ad + 24'(l);
      left = left - l;
    end
  endtask

  // start a list, wait for its end, compare the command log
  task automatic run_list(input int c, input int base, input string req, input int second_base);
    int d0;
    int t;
    n_log = 0;
    d0 = done_cnt;
    @(negedge clk);
    start_valid = 1'b1; start_client = 2'(c); start_base = 6'(base);
    @(negedge clk);
    start_valid = 1'b0;
    chk(busy === 1'b1, "R1", "busy after start", 64'(busy), 64'd1);
    if (second_base >= 0) begin
      @(negedge clk);
      start_valid = 1'b1; start_client = 2'(c); start_base = 6'(second_base);
      @(negedge clk);
      start_valid = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done_cnt == d0 + 1, "R3", "done seen", 64'(done_cnt - d0), 64'd1);
    chk(n_log == n_exp, req, "command count at done", 64'(n_log), 64'(n_exp));
    for (int i = 0; i < n_log && i < n_exp; i++) begin
      bit ok;
      ok = (lg_w[i] == ex_w[i]) && (lg_f[i] == ex_f[i]) && (lg_a[i] == ex_a[i]) &&
           (lg_l[i] == ex_l[i]) && (lg_c[i] == ex_c[i]) && (!ex_f[i] || lg_p[i] == ex_p[i]);
      chk(ok, req, $sformatf("cmd %0d {w,f,addr,len,cli,pat}", i),
          {lg_w[i], lg_f[i], 2'(lg_c[i]), lg_a[i][11:0], 16'(lg_l[i]), lg_p[i]},
          {ex_w[i], ex_f[i], 2'(ex_c[i]), ex_a[i][11:0], 16'(ex_l[i]), ex_p[i]});
    end
    repeat (12) @(negedge clk);
    chk(!mc_valid && n_log == n_exp && done_cnt == d0 + 1, "R3", "quiet after end (R1 second start ignored)",
        64'(n_log), 64'(n_exp));
    n_exp = 0;
  endtask

  initial begin : watchdog
    while (cycles < 150000 && !finished) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int cnts [6];
    cnts = '{0, 1, 3, 5, 8, 17};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(busy === 1'b0, "R9", "busy after reset", 64'(busy), 64'd0);
    chk(done === 1'b0, "R9", "done after reset", 64'(done), 64'd0);
    chk(mc_valid === 1'b0, "R9", "mc_valid after reset", 64'(mc_valid), 64'd0);

    // R9/R7: no fill mode after reset, so the write uses the staging buffer
    wr(16, mkreq(2, 24'h0A0000)); wr(17, 32'd4); wr(18, 32'd0); wr(19, 32'd0);
    add_exp(1'b1, 1'b0, 24'h0A0000, 4, 0, 32'd0);
    run_list(0, 16, "R9", -1);

    // R4/R5: sweep client, size and count
    for (int c = 0; c < NC; c++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int k = 0; k < 6; k++) begin
          int base;
          logic [31:0] pat;
          logic [23:0] a;
          base = 2 * (c + sz);
          pat = 32'h3C5A_96E1 + 32'(c * 977 + sz * 131 + cnts[k] * 7);
          a = 24'hFFFFE0 + 24'(c * 4 + cnts[k]);
          ack_delay = (c + k) % 3;
          wr(base, mkreq(3, 24'(sz))); wr(base + 1, pat);
          wr(base + 2, mkreq(2, a));   wr(base + 3, 32'(cnts[k]));
          wr(base + 4, 32'd0);         wr(base + 5, 32'd0);
          exp_fill(c, a, cnts[k] << sz, spread(sz, pat));
          run_list(c, base, "R5", -1);
          lastpat[c] = pat;
          lastsz[c] = sz;
        end
      end
    end

    // R4: size code 3 acts as 32-bit
    wr(0, mkreq(3, 24'd3)); wr(1, 32'hDEAD_BEEF);
    wr(2, mkreq(2, 24'h0B0000)); wr(3, 32'd5);
    wr(4, 32'd0); wr(5, 32'd0);
    exp_fill(1, 24'h0B0000, 20, 32'hDEAD_BEEF);
    run_list(1, 0, "R4", -1);
    lastpat[1] = 32'hDEAD_BEEF;
    lastsz[1] = 2;

    // R7: copy as read then write through the staging buffer
    ack_delay = 2;
    wr(20, mkreq(1, 24'h100000)); wr(21, 32'd64);
    wr(22, mkreq(2, 24'h200000)); wr(23, 32'd64);
    wr(24, 32'd0); wr(25, 32'd0);
    add_exp(1'b0, 1'b0, 24'h100000, 64, 3, 32'd0);
    add_exp(1'b1, 1'b0, 24'h200000, 64, 3, 32'd0);
    run_list(3, 20, "R7", -1);

    // R2: unknown operation issues nothing; R3: empty list
    wr(26, mkreq(7, 24'h123456)); wr(27, 32'd99);
    wr(28, 32'd0); wr(29, 32'd0);
    wr(30, 32'd0); wr(31, 32'd0);
    run_list(2, 26, "R2", -1);
    run_list(2, 30, "R3", -1);

    // R1: a start during a busy list is ignored
    ack_delay = 1;
    add_exp(1'b0, 1'b0, 24'h100000, 64, 3, 32'd0);
    add_exp(1'b1, 1'b0, 24'h200000, 64, 3, 32'd0);
    run_list(3, 20, "R1", 30);

    // R6: persistence, off, on again with stored pattern
    ack_delay = 0;
    wr(32, mkreq(3, 24'd1));        wr(33, 32'h0000_1234);
    wr(34, mkreq(2, 24'h001000));   wr(35, 32'd3);
    wr(36, mkreq(2, 24'h002000));   wr(37, 32'd10);
    wr(38, mkreq(4, 24'd0));        wr(39, 32'd0);
    wr(40, mkreq(2, 24'h003000));   wr(41, 32'd40);
    wr(42, mkreq(4, 24'd1));        wr(43, 32'd0);
    wr(44, mkreq(2, 24'h004000));   wr(45, 32'd2);
    wr(46, mkreq(1, 24'h005000));   wr(47, 32'd7);
    wr(48, 32'd0);                  wr(49, 32'd0);
    exp_fill(1, 24'h001000, 6, 32'h1234_1234);
    exp_fill(1, 24'h002000, 20, 32'h1234_1234);
    add_exp(1'b1, 1'b0, 24'h003000, 40, 1, 32'd0);
    exp_fill(1, 24'h004000, 4, 32'h1234_1234);
    add_exp(1'b0, 1'b0, 24'h005000, 7, 1, 32'd0);
    run_list(1, 32, "R6", -1);

    // R6: list end cleared fill mode
    wr(50, mkreq(2, 24'h006000)); wr(51, 32'd5);
    wr(52, 32'd0); wr(53, 32'd0);
    add_exp(1'b1, 1'b0, 24'h006000, 5, 1, 32'd0);
    run_list(1, 50, "R6", -1);

    // R6: re-enabled mode uses this client's own stored pattern
    wr(54, mkreq(4, 24'd1));      wr(55, 32'd0);
    wr(56, mkreq(2, 24'h007000)); wr(57, 32'd9);
    wr(58, 32'd0);                wr(59, 32'd0);
    exp_fill(2, 24'h007000, 9 << lastsz[2], spread(lastsz[2], lastpat[2]));
    run_list(2, 54, "R6", -1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule